// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip request port and an external static RAM that has no clock of its own. The RAM holds 524,288 words of 16 bits and is steered by three active-low strobes: chip select, output drive and write strobe. Each accepted request is a single-word read or write. The controller turns it into a strobe sequence whose phases last a whole number of clock cycles. Those counts are parameters, chosen by dividing the RAM's nanosecond limits by the clock period and rounding up.

The 16-bit data pins are split into three signals: an outbound word, an inbound word and a drive enable, which the pad ring combines. Reads hold chip select and output drive low for a set number of cycles. The controller samples the bus on the last of those cycles and presents the word with a one-cycle valid pulse. Writes follow a fixed order: address and strobes settle, the write strobe goes low while the data word is driven, and one hold cycle follows. A read followed by a write gets an idle gap, so that the RAM has released the bus before the controller drives it.

Top module: `sram_ctl`

## Requirements
- R1: After reset and between transactions, chip select, output drive and write strobe are all high (1), the data drive enable is low, and `req_ready` is high.
- R2: A read holds chip select low, output drive low and write strobe high for exactly RD_CYC cycles, with the request address on `mem_addr`. In the following cycle, `rd_valid` is high for exactly one cycle and `rd_data` carries the bus value sampled in the last strobe cycle.
- R3: `req_ready` is low for the whole of a transaction. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and with `req_valid` low the strobes stay high.
- R4: A write begins with one setup cycle in which chip select is low, output drive and write strobe are high, the address is on `mem_addr`, and the data bus is not driven.
- R5: During a write, the write strobe is low for exactly WR_PULSE consecutive cycles. Chip select stays low throughout, and `mem_dq_oe` is high with the write word on `mem_dq_out`.
- R6: After the write strobe rises, one hold cycle keeps chip select low, `mem_dq_oe` high, and the address and data unchanged. In the next cycle the bus is released and chip select is high.
- R7: When a write request follows a read, exactly max(TURN,1) cycles with all strobes high separate the last read-strobe cycle from the write setup cycle. The data bus is never driven while output drive may still be active.
- R8: A read request waiting during the `rd_valid` cycle of a previous read is accepted at once, giving exactly one idle cycle between the two reads.
- R9: The write strobe is low only while chip select is low and output drive is high, and output drive is low only while the write strobe is high (write wins over read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| rd_valid | output | 1 | One-cycle read-result strobe |
| rd_data | output | 16 | Read result |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output drive, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 16 | Word driven onto the data pins |
| mem_dq_in | input | 16 | Word seen on the data pins |
| mem_dq_oe | output | 1 | Data pin drive enable, active high |

## Verification
The bench builds the controller with RD_CYC = 3, WR_PULSE = 3 and TURN = 2, which are larger than the defaults. Three-cycle phases separate the first, middle and last strobe cycles, so an off-by-one in a phase counter appears as a wrong strobe length. A TURN of 2 takes the turnaround counter out of its degenerate one-cycle form, so the read-to-write gap can be told apart from the ordinary idle cycle that every transaction ends with. The highest address and an all-ones word exercise the full width of both buses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_READ   = 3'd1,
      PH_WSETUP = 3'd2,
      PH_WPULSE = 3'd3,
      PH_WHOLD  = 3'd4
   } phase_t;

   typedef struct packed {
      logic ce_n;
      logic oe_n;
      logic we_n;
      logic dq_oe;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

   function automatic strobe_t strobe_of(phase_t ph);
      strobe_t s;
      s = STROBE_IDLE;
      case (ph)
         PH_READ:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
         PH_WSETUP: begin s.ce_n = 1'b0; end
         PH_WPULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
         PH_WHOLD:  begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
         default:   s = STROBE_IDLE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int RD_CYC   = 2,
   parameter int WR_PULSE = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   take,
   input  logic   take_write,
   output phase_t phase_q,
   output phase_t phase_d,
   output logic   rd_last
);

   localparam int LONGEST = (RD_CYC > WR_PULSE) ? RD_CYC : WR_PULSE;
   localparam int CNT_W   = (LONGEST < 2) ? 1 : $clog2(LONGEST);
   localparam logic [CNT_W-1:0] RD_END = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_END = CNT_W'(WR_PULSE - 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q + 1'b1;
      case (phase_q)
         PH_IDLE: begin
            cnt_d = '0;
            if (take) phase_d = take_write ? PH_WSETUP : PH_READ;
         end
         PH_READ: begin
            if (cnt_q == RD_END) begin
               phase_d = PH_IDLE;
               cnt_d   = '0;
            end
         end
         PH_WSETUP: begin
            phase_d = PH_WPULSE;
            cnt_d   = '0;
         end
         PH_WPULSE: begin
            if (cnt_q == WR_END) begin
               phase_d = PH_WHOLD;
               cnt_d   = '0;
            end
         end
         PH_WHOLD: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
         default: begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   assign rd_last = (phase_q == PH_READ) && (cnt_q == RD_END);

endmodule

// File: rtl/sram_ctl_gap.sv
module sram_ctl_gap #(
   parameter int TURN = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_last,
   output logic wr_ok
);

   generate
      if (TURN > 1) begin : g_count
         localparam int GW = $clog2(TURN + 1);
         logic [GW-1:0] gap_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               gap_q <= '0;
            else if (rd_last)
               gap_q <= GW'(TURN);
            else if (gap_q != '0)
               gap_q <= gap_q - 1'b1;
         end

         // the cycle holding value 1 is the TURN-th idle cycle
         assign wr_ok = (gap_q <= GW'(1));
      end else begin : g_none
         // the idle cycle after every read already covers one cycle
         logic gap_unused;
         assign gap_unused = ^{clk, rst_n, rd_last};
         assign wr_ok      = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sram_ctl_io.sv
module sram_ctl_io
   import sram_ctl_pkg::*;
#(
   parameter int AW = 19,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  phase_t        phase_d,
   input  logic          rd_last,
   input  logic [DW-1:0] mem_dq_in,
   output strobe_t       pins_q,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          rd_valid_q,
   output logic [DW-1:0] rd_data_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pins_q <= STROBE_IDLE;
      end else begin
         pins_q <= strobe_of(phase_d);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (take) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= '0;
      end else begin
         rd_valid_q <= rd_last;
         if (rd_last) rd_data_q <= mem_dq_in;
      end
   end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW       = 19,
   parameter int DW       = 16,
   parameter int RD_CYC   = 2,
   parameter int WR_PULSE = 2,
   parameter int TURN     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n,
   output logic [DW-1:0] mem_dq_out,
   input  logic [DW-1:0] mem_dq_in,
   output logic          mem_dq_oe
);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_ctl: bus widths must be positive");
      end
      if (RD_CYC < 1) begin : g_bad_rd
         $error("sram_ctl: RD_CYC must be at least 1");
      end
      if (WR_PULSE < 1) begin : g_bad_wr
         $error("sram_ctl: WR_PULSE must be at least 1");
      end
      if (TURN < 0) begin : g_bad_turn
         $error("sram_ctl: TURN must not be negative");
      end
   endgenerate

   phase_t  phase_q, phase_d;
   logic    rd_last, wr_ok, take;
   strobe_t pins_q;

   assign req_ready = (phase_q == PH_IDLE) && (!req_write || wr_ok);
   assign take      = req_valid && req_ready;

   sram_ctl_seq #(
      .RD_CYC   (RD_CYC),
      .WR_PULSE (WR_PULSE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .take_write (req_write),
      .phase_q    (phase_q),
      .phase_d    (phase_d),
      .rd_last    (rd_last)
   );

   sram_ctl_gap #(
      .TURN (TURN)
   ) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_last (rd_last),
      .wr_ok   (wr_ok)
   );

   sram_ctl_io #(
      .AW (AW),
      .DW (DW)
   ) u_io (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .phase_d    (phase_d),
      .rd_last    (rd_last),
      .mem_dq_in  (mem_dq_in),
      .pins_q     (pins_q),
      .addr_q     (mem_addr),
      .wdata_q    (mem_dq_out),
      .rd_valid_q (rd_valid),
      .rd_data_q  (rd_data)
   );

   assign mem_ce_n  = pins_q.ce_n;
   assign mem_oe_n  = pins_q.oe_n;
   assign mem_we_n  = pins_q.we_n;
   assign mem_dq_oe = pins_q.dq_oe;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
   parameter int AW       = 19,
   parameter int DW       = 16,
   parameter int RD_CYC   = 2,
   parameter int WR_PULSE = 2,
   parameter int TURN     = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rd_valid,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ce_n,
   input logic          mem_oe_n,
   input logic          mem_we_n,
   input logic [DW-1:0] mem_dq_out,
   input logic          mem_dq_oe
);

   localparam int RW = $clog2(((RD_CYC > WR_PULSE) ? RD_CYC : WR_PULSE) + 2);

   logic [RW-1:0] we_run, oe_run;
   logic          chk_unused;
   assign chk_unused = (TURN < 0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_run <= '0;
         oe_run <= '0;
      end else begin
         we_run <= mem_we_n ? '0 : we_run + 1'b1;
         oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
      end
   end

   // R1: quiet bus whenever chip select is high
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_dq_oe));

   // R2: read strobe lasts exactly RD_CYC cycles
   a_r2_read_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_run == RW'(RD_CYC)));

   // R2: result strobe is a single-cycle pulse
   a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R3: no acceptance while the RAM is selected
   a_r3_busy: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n);

   // R4: write strobe falls only after a selected setup cycle with output drive off
   a_r4_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_oe_n) && $past(mem_we_n)));

   // R5: write strobe low for exactly WR_PULSE cycles
   a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run == RW'(WR_PULSE)));

   // R5: address and data steady while the write strobe stays low
   a_r5_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

   // R6: one hold cycle after the write strobe rises
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

   // R7: data bus never driven together with output drive
   a_r7_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

   // R9: write beats read
   a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(
   .AW       (AW),
   .DW       (DW),
   .RD_CYC   (RD_CYC),
   .WR_PULSE (WR_PULSE),
   .TURN     (TURN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;

   localparam int AW = 19;
   localparam int DW = 16;
   localparam int RD = 3;
   localparam int WP = 3;
   localparam int TN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] mem_addr;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   int n_run = 0;
   int n_bad = 0;
   int since_oe = 1000;
   logic prev_dq_oe = 1'b0;
   logic [DW-1:0] ram [0:255];

   always #2.5 clk = ~clk;

   sram_ctl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WR_PULSE(WP), .TURN(TN)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   // behavioural RAM: drives only when selected for reading
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? ram[mem_addr[7:0]] : 16'hDEAD;

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[mem_addr[7:0]] <= mem_dq_out;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // R7: bus drive may start only after TURN idle cycles plus the setup cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_oe_n) since_oe = 0;
         else if (since_oe < 1000) since_oe++;
         if (mem_dq_oe && !prev_dq_oe)
            chk(since_oe >= TN + 2, "R7 drive after read", since_oe, TN + 2);
         prev_dq_oe = mem_dq_oe;
      end
   end

   task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic rd_strobes(input logic [AW-1:0] a);
      for (int k = 0; k < RD; k++) begin
         chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
         chk(mem_addr == a, "R2 read address", mem_addr, a);
         chk(!req_ready, "R3 busy during read", req_ready, 0);
         @(negedge clk);
      end
   endtask

   task automatic rd_result(input logic [DW-1:0] exp);
      chk(rd_valid && rd_data == exp, "R2 read data", {rd_valid, rd_data}, {1'b1, exp});
      chk(mem_ce_n, "R1 idle after read", mem_ce_n, 1);
      @(negedge clk);
      chk(!rd_valid, "R2 single pulse", rd_valid, 0);
   endtask

   task automatic wr_body(input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk(!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R4 setup cycle",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0110);
      chk(mem_addr == a, "R4 setup address", mem_addr, a);
      @(negedge clk);
      for (int k = 0; k < WP; k++) begin
         chk(!mem_ce_n && mem_oe_n && !mem_we_n && mem_dq_oe, "R5 write pulse",
             {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0101);
         chk(mem_dq_out == d && mem_addr == a, "R5 write word", mem_dq_out, d);
         chk(!req_ready, "R3 busy during write", req_ready, 0);
         @(negedge clk);
      end
      chk(!mem_ce_n && mem_we_n && mem_dq_oe && mem_dq_out == d && mem_addr == a, "R6 hold cycle",
          {mem_ce_n, mem_we_n, mem_dq_oe, mem_dq_out}, {3'b011, d});
      @(negedge clk);
      chk(mem_ce_n && !mem_dq_oe && req_ready, "R6 release", {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);
   endtask

   task automatic t_reset();
      chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1 reset state",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
   endtask

   task automatic t_no_request();
      int hit = 0;
      req_write = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         if (!mem_ce_n || rd_valid) hit++;
      end
      chk(hit == 0, "R3 no valid no access", hit, 0);
   endtask

   task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      issue(1'b1, a, d);
      wr_body(a, d);
   endtask

   task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
      issue(1'b0, a, '0);
      rd_strobes(a);
      rd_result(exp);
   endtask

   task automatic t_back_to_back(input logic [AW-1:0] a, input logic [AW-1:0] b);
      issue(1'b0, a, '0);
      rd_strobes(a);
      chk(rd_valid && rd_data == ram[a[7:0]], "R8 first result", rd_data, ram[a[7:0]]);
      req_valid = 1'b1; req_write = 1'b0; req_addr = b;
      chk(req_ready, "R8 ready in result cycle", req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!mem_ce_n && !mem_oe_n, "R8 next read at once", {mem_ce_n, mem_oe_n}, 2'b00);
      rd_strobes(b);
      rd_result(ram[b[7:0]]);
   endtask

   task automatic t_turnaround(input logic [AW-1:0] ra, input logic [AW-1:0] wa, input logic [DW-1:0] wd);
      int idle = 0;
      logic [DW-1:0] exp;
      exp = ram[ra[7:0]];
      issue(1'b0, ra, '0);
      req_valid = 1'b1; req_write = 1'b1; req_addr = wa; req_wdata = wd;
      rd_strobes(ra);
      chk(rd_valid && rd_data == exp, "R2 result before write", rd_data, exp);
      while (mem_ce_n && idle < 20) begin
         chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R7 gap quiet", {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
         idle++;
         @(negedge clk);
      end
      req_valid = 1'b0;
      chk(idle == TN, "R7 gap length", idle, TN);
      wr_body(wa, wd);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ram[i] = 16'hA000 | 16'(i);
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_request();
      t_write(19'h00012, 16'h5A5A);
      t_read(19'h00012, 16'h5A5A);
      t_read(19'h00040, 16'hA040);
      t_write(19'h7FFFF, 16'hFFFF);
      t_read(19'h7FFFF, 16'hFFFF);
      t_back_to_back(19'h00033, 19'h00034);
      t_turnaround(19'h00012, 19'h00077, 16'h1234);
      t_read(19'h00077, 16'h1234);
      t_write(19'h00001, 16'h0F0F);
      t_write(19'h00002, 16'hF0F0);
      t_read(19'h00001, 16'h0F0F);
      t_read(19'h00002, 16'hF0F0);
      repeat (3) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule